// File: doc/BRIEF.md
# Page Program Buffer with Column Wrap

This block gathers the data bytes of one page-program instruction into a page-wide staging buffer. Each column of the page has a byte register and a valid bit. A start strobe loads the starting column from the low address bits and clears the buffer. Each accepted data byte goes to the current column, and the column pointer then advances. The pointer wraps from the last column of the page back to column 0. When more bytes arrive than the page holds, the later bytes overwrite the earlier ones, so the last page-worth of bytes is kept.

A commit strobe merges the buffer with the current page image supplied by the storage backend. Programming can only clear bits. Each received column becomes the old byte ANDed with the new byte, and every other column keeps its old content. The merged page and the per-column write mask are registered for write-back, and a done pulse follows one cycle after they settle. An abort strobe cancels the pending instruction. The serial front end raises abort when chip select rises in the middle of a byte. After an abort there is no merge and no done, and the last results stay on the outputs.

Top module: `page_prog_buffer`

## Requirements
- R1: After reset, `mergedPage` and `writeMask` are all zero and `doneStb` is low.
- R2: After a start, the n-th accepted byte (counting from 0) is stored at column (startCol + n) mod PAGE_BYTES. On commit, that column's `writeMask` bit is 1. Column c occupies `mergedPage[c*8 +: 8]` and `writeMask[c]`.
- R3: A column past PAGE_BYTES-1 wraps to column 0 of the same page.
- R4: When more than PAGE_BYTES bytes are accepted, each column holds the last byte written to it, so only the last PAGE_BYTES bytes take effect.
- R5: A column that received no byte has its `writeMask` bit at 0, and its merged byte equals the old byte.
- R6: A received column merges to old AND new. The merged page never holds a 1 where the old image held a 0.
- R7: A start clears every byte and valid bit left from an earlier instruction, whether that instruction was committed or aborted.
- R8: Abort during collection cancels the instruction. No done pulse follows, `mergedPage` and `writeMask` keep their earlier values, and a later commit is ignored until the next start.
- R9: `mergedPage` and `writeMask` update at the clock edge that accepts a commit. `doneStb` is high for exactly one cycle, starting one edge later. The outputs change only at an accepted commit.
- R10: Data bytes and commits that arrive outside a collection (before any start, or after a commit or abort) have no effect on the outputs and raise no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Begins a new program instruction |
| startCol | input | ADDR_W | Starting column (low address bits) |
| byteValid | input | 1 | A data byte is present on byteData |
| byteData | input | 8 | Data byte |
| commitStb | input | 1 | Merge the buffer with the old page |
| abortStb | input | 1 | Cancel the pending instruction |
| oldPage | input | PAGE_BYTES*8 | Current page image from the backend |
| mergedPage | output | PAGE_BYTES*8 | Merged page for write-back |
| writeMask | output | PAGE_BYTES | Columns written by this instruction |
| doneStb | output | 1 | One-cycle pulse after the merge settles |

## Verification
The assertions check on every cycle that the merge only ever clears bits relative to the old image. They also check that the outputs move only on a merge, and that the done pulse lasts one cycle and comes exactly two edges after a merge. Column placement cannot be seen from a single cycle. That covers wrap at the page end, overwrite on overflow, untouched columns and clearing between instructions. The bench's sweeps over every start column and several byte counts show these by comparing whole pages against arithmetic expectations, and so do its abort and out-of-sequence scenarios.

// File: rtl/page_prog_buffer_pkg.sv
package page_prog_buffer_pkg;

  typedef enum logic [1:0] {
    PG_IDLE   = 2'd0,
    PG_FILL   = 2'd1,
    PG_SETTLE = 2'd2
  } pgState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;   // reload pointer, empty buffer
    logic write;   // store byte at pointer, advance
    logic merge;   // register merged page and mask
  } pgCtl_t;

endpackage

// File: rtl/page_prog_buffer_ctrl.sv
module page_prog_buffer_ctrl
  import page_prog_buffer_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startStb,
  input  logic   byteValid,
  input  logic   commitStb,
  input  logic   abortStb,
  output pgCtl_t ctl,
  output logic   doneStb
);

  pgState_e state, stateNxt;
  logic     doneQ;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    unique case (state)
      PG_IDLE: begin
        if (startStb) begin
          ctl.clear = 1'b1;
          stateNxt  = PG_FILL;
        end
      end
      PG_FILL: begin
        if (startStb) begin
          ctl.clear = 1'b1;
        end else if (abortStb) begin
          ctl.clear = 1'b1;
          stateNxt  = PG_IDLE;
        end else if (commitStb) begin
          ctl.merge = 1'b1;
          stateNxt  = PG_SETTLE;
        end else if (byteValid) begin
          ctl.write = 1'b1;
        end
      end
      PG_SETTLE: begin
        if (startStb) begin
          ctl.clear = 1'b1;
          stateNxt  = PG_FILL;
        end else begin
          stateNxt  = PG_IDLE;
        end
      end
      default: stateNxt = PG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= PG_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNxt;
      doneQ <= (state == PG_SETTLE);
    end
  end

  assign doneStb = doneQ;

endmodule

// File: rtl/page_prog_buffer_datapath.sv
module page_prog_buffer_datapath
  import page_prog_buffer_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int ADDR_W     = $clog2(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pgCtl_t                  ctl,
  input  logic [ADDR_W-1:0]       startCol,
  input  logic [7:0]              byteData,
  input  logic [PAGE_BYTES*8-1:0] oldPage,
  output logic [PAGE_BYTES*8-1:0] mergedPage,
  output logic [PAGE_BYTES-1:0]   writeMask
);

  localparam logic [ADDR_W-1:0] LAST_COL = ADDR_W'(PAGE_BYTES - 1);

  logic [ADDR_W-1:0] colPtr;
  logic [7:0]        bufData [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bufValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colPtr <= '0;
    end else if (ctl.clear) begin
      colPtr <= startCol;
    end else if (ctl.write) begin
      colPtr <= (colPtr == LAST_COL) ? '0 : colPtr + 1'b1;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    logic hit;
    assign hit = ctl.write && (colPtr == ADDR_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bufData[g]  <= 8'hFF;
        bufValid[g] <= 1'b0;
      end else if (ctl.clear) begin
        bufData[g]  <= 8'hFF;
        bufValid[g] <= 1'b0;
      end else if (hit) begin
        bufData[g]  <= byteData;
        bufValid[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        mergedPage[g*8 +: 8] <= 8'h00;
        writeMask[g]         <= 1'b0;
      end else if (ctl.merge) begin
        mergedPage[g*8 +: 8] <= bufValid[g] ? (oldPage[g*8 +: 8] & bufData[g])
                                            : oldPage[g*8 +: 8];
        writeMask[g]         <= bufValid[g];
      end
    end
  end

endmodule

// File: rtl/page_prog_buffer.sv
module page_prog_buffer
  import page_prog_buffer_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int ADDR_W     = $clog2(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startStb,
  input  logic [ADDR_W-1:0]       startCol,
  input  logic                    byteValid,
  input  logic [7:0]              byteData,
  input  logic                    commitStb,
  input  logic                    abortStb,
  input  logic [PAGE_BYTES*8-1:0] oldPage,
  output logic [PAGE_BYTES*8-1:0] mergedPage,
  output logic [PAGE_BYTES-1:0]   writeMask,
  output logic                    doneStb
);

  pgCtl_t ctl;
  logic   mergeFire;

  page_prog_buffer_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startStb  (startStb),
    .byteValid (byteValid),
    .commitStb (commitStb),
    .abortStb  (abortStb),
    .ctl       (ctl),
    .doneStb   (doneStb)
  );

  page_prog_buffer_datapath #(
    .PAGE_BYTES (PAGE_BYTES),
    .ADDR_W     (ADDR_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .startCol   (startCol),
    .byteData   (byteData),
    .oldPage    (oldPage),
    .mergedPage (mergedPage),
    .writeMask  (writeMask)
  );

  assign mergeFire = ctl.merge;

endmodule

// File: rtl/page_prog_buffer_chk.sv
module page_prog_buffer_chk #(
  parameter int PAGE_BYTES = 256
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [PAGE_BYTES*8-1:0] oldPage,
  input logic [PAGE_BYTES*8-1:0] mergedPage,
  input logic [PAGE_BYTES-1:0]   writeMask,
  input logic                    doneStb,
  input logic                    mergeFire
);

  // R6: merge never sets a bit the old image had cleared
  p_program_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(mergeFire) |-> ((mergedPage & ~$past(oldPage)) == '0));

  // R9: outputs move only on an accepted merge (covers abort, R8)
  p_hold_outputs_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(mergeFire) |-> ($stable(mergedPage) && $stable(writeMask)));

  // R9: done follows a merge by exactly two edges
  p_done_after_merge_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(mergeFire, 2) |-> doneStb);

  // R8: no done without a preceding merge
  p_done_needs_merge_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> $past(mergeFire, 2));

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb);

  // R9: results are already stable while done is high
  p_stable_at_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> ($stable(mergedPage) && $stable(writeMask)));

endmodule

bind page_prog_buffer page_prog_buffer_chk #(
  .PAGE_BYTES (PAGE_BYTES)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .oldPage    (oldPage),
  .mergedPage (mergedPage),
  .writeMask  (writeMask),
  .doneStb    (doneStb),
  .mergeFire  (mergeFire)
);

// File: tb/page_prog_buffer_tb_top.sv
module page_prog_buffer_tb_top;

  localparam int PG = 16;
  localparam int AW = $clog2(PG);

  logic            clk = 1'b0;
  logic            rstN;
  logic            startStb, byteValid, commitStb, abortStb;
  logic [AW-1:0]   startCol;
  logic [7:0]      byteData;
  logic [PG*8-1:0] oldPage, mergedPage;
  logic [PG-1:0]   writeMask;
  logic            doneStb;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [7:0] expData [PG];
  logic       expVal  [PG];

  always #5 clk = ~clk;

  page_prog_buffer #(.PAGE_BYTES(PG)) dut_i (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startCol(startCol),
    .byteValid(byteValid), .byteData(byteData), .commitStb(commitStb),
    .abortStb(abortStb), .oldPage(oldPage), .mergedPage(mergedPage),
    .writeMask(writeMask), .doneStb(doneStb)
  );

  task automatic check(input string req, input logic [PG*8-1:0] act,
                       input logic [PG*8-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doStart(input int col);
    @(negedge clk); startStb = 1'b1; startCol = AW'(col);
    @(negedge clk); startStb = 1'b0;
  endtask

  task automatic sendBytes(input int s, input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byteValid = 1'b1;
      byteData  = 8'((i * 37 + s * 11 + seed * 5 + 3) & 255);
    end
    @(negedge clk); byteValid = 1'b0;
  endtask

  function automatic void buildExp(input int s, input int n, input int seed);
    for (int c = 0; c < PG; c++) begin expData[c] = 8'hFF; expVal[c] = 1'b0; end
    for (int i = 0; i < n; i++) begin
      int c = (s + i) % PG;
      expData[c] = 8'((i * 37 + s * 11 + seed * 5 + 3) & 255);
      expVal[c]  = 1'b1;
    end
  endfunction

  function automatic logic [PG*8-1:0] mkOld(input int seed);
    logic [PG*8-1:0] v;
    for (int c = 0; c < PG; c++) v[c*8 +: 8] = 8'(((c * 53) ^ (seed * 29) ^ 8'hB7) & 255);
    return v;
  endfunction

  // commit then check page, mask, program-only, and done timing
  task automatic commitCheck(input string req);
    logic [PG*8-1:0] expPage, expMask;
    expMask = '0;
    for (int c = 0; c < PG; c++) begin
      expPage[c*8 +: 8] = expVal[c] ? (oldPage[c*8 +: 8] & expData[c]) : oldPage[c*8 +: 8];
      expMask[c] = expVal[c];
    end
    @(negedge clk); commitStb = 1'b1;
    @(negedge clk); commitStb = 1'b0;
    check({req, " page"}, mergedPage, expPage);
    check({req, " mask"}, {{(PG*7){1'b0}}, writeMask}, expMask);
    check("R6 no set bits", mergedPage & ~oldPage, '0);
    check("R9 done low at merge", {{(PG*8-1){1'b0}}, doneStb}, '0);
    @(negedge clk);
    check("R9 done high", {{(PG*8-1){1'b0}}, doneStb}, 1);
    check("R9 page held", mergedPage, expPage);
    @(negedge clk);
    check("R9 done one cycle", {{(PG*8-1){1'b0}}, doneStb}, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [PG*8-1:0] lastPage;
    logic [PG-1:0]   lastMask;
    int counts [4] = '{1, 7, 16, 23};
    rstN = 1'b0; startStb = 0; byteValid = 0; commitStb = 0; abortStb = 0;
    startCol = '0; byteData = '0; oldPage = mkOld(0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check("R1 page", mergedPage, '0);
    check("R1 mask", {{(PG*7){1'b0}}, writeMask}, '0);
    check("R1 done", {{(PG*8-1){1'b0}}, doneStb}, '0);

    // R10: bytes and commit without a start
    sendBytes(0, 3, 1);
    @(negedge clk); commitStb = 1'b1;
    @(negedge clk); commitStb = 1'b0;
    @(negedge clk);
    check("R10 page untouched", mergedPage, '0);
    check("R10 mask untouched", {{(PG*7){1'b0}}, writeMask}, '0);
    check("R10 no done", {{(PG*8-1){1'b0}}, doneStb}, '0);

    // R2 R3 R4 R5 sweep: every start column, several counts
    for (int s = 0; s < PG; s++) begin
      for (int k = 0; k < 4; k++) begin
        int n = counts[k];
        oldPage = mkOld(s * 4 + k + 1);
        doStart(s);
        sendBytes(s, n, k);
        buildExp(s, n, k);
        if (n > PG)             commitCheck("R4 overflow");
        else if (s + n > PG)    commitCheck("R3 wrap");
        else if (n < PG)        commitCheck("R5 partial");
        else                    commitCheck("R2 full");
      end
    end

    // R8: abort keeps outputs, later commit ignored
    lastPage = mergedPage; lastMask = writeMask;
    oldPage = mkOld(99);
    doStart(5);
    sendBytes(5, 4, 9);
    @(negedge clk); abortStb = 1'b1;
    @(negedge clk); abortStb = 1'b0;
    @(negedge clk); commitStb = 1'b1;
    @(negedge clk); commitStb = 1'b0;
    check("R8 page kept", mergedPage, lastPage);
    check("R8 mask kept", {{(PG*7){1'b0}}, writeMask}, {{(PG*7){1'b0}}, lastMask});
    @(negedge clk);
    check("R8 no done", {{(PG*8-1){1'b0}}, doneStb}, '0);
    @(negedge clk);
    check("R8 no done later", {{(PG*8-1){1'b0}}, doneStb}, '0);

    // R7: new start after abort holds only fresh bytes
    doStart(2);
    sendBytes(2, 2, 3);
    buildExp(2, 2, 3);
    commitCheck("R7 cleared after abort");

    // R7: new start after a full commit, zero bytes
    doStart(0);
    sendBytes(0, PG, 2);
    buildExp(0, PG, 2);
    commitCheck("R2 full page");
    doStart(7);
    buildExp(7, 0, 0);
    commitCheck("R7 cleared after commit");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule